// File: doc/BRIEF.md
# Processor interrupt pin conditioner

This block sits between the external control pins of a processor and its interrupt and reset logic. Each pin change arrives as an indexed write of a new level. The block keeps a register with the last level seen on every pin. A write only counts as an event when the new level differs from the stored one. Each event is decoded by the type of its pin: active-high level, active-low level or falling edge.

Events on interrupt-type pins set or clear bits of a pending vector. A summary request follows the whole vector. The remaining pins drive three outputs: a sticky halt, a time-base run enable and a one-cycle reset request. A separate acknowledge input clears the sticky machine-check bit.

Every output is registered. Its new value appears in the cycle after the clock edge that samples the write.

Top module: `pin_conditioner`

## Requirements
- R1: A write whose level equals the stored level of that pin is not an event: irq_pending_o, halt_o, tb_run_o and reset_req_o stay as they are.
- R2: Every write stores its level for that pin, visible on pin_state_o after the edge; after reset pin_state_o is 8'h30 (bits 4 and 5 high, all others low).
- R3: Pin 0 (external interrupt) and pin 1 (system-management interrupt) are active-high levels: an event with level 1 sets, and with level 0 clears, pending bit 0 and bit 1 respectively.
- R4: Pin 2 (machine check) acts on a falling edge: a 1-to-0 event sets pending bit 2; a rising event leaves it unchanged; the bit stays set until acknowledged.
- R5: A high on mchk_ack_i clears pending bit 2; when a falling-edge event on pin 2 lands in the same cycle, the bit ends up set.
- R6: Pin 3 (time-base enable) is an active-high level: an event with level 1 sets tb_run_o and an event with level 0 clears it; tb_run_o is 0 after reset.
- R7: Pin 4 (checkstop, active-low): an event with level 0 sets halt_o, which then stays high until reset.
- R8: Pin 5 (hard reset, active-low): an event with level 0 gives reset_req_o high for exactly one cycle.
- R9: Pin 6 (soft reset) sets pending bit 3 on an event with level 1 and clears it on an event with level 0.
- R10: irq_req_o is high exactly when irq_pending_o is non-zero; clearing one bit keeps it high while any other bit is set.
- R11: Pin 7 has no function: writes to it change no output except its own bit of pin_state_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_we_i | input | 1 | Pin level write strobe |
| pin_idx_i | input | 3 | Index of the pin being written |
| pin_lvl_i | input | 1 | New level of the pin |
| mchk_ack_i | input | 1 | Clears the machine-check pending bit |
| pin_state_o | output | 8 | Stored level of every pin |
| irq_pending_o | output | 4 | Pending bits: 0 ext, 1 smi, 2 mchk, 3 soft reset |
| irq_req_o | output | 1 | Summary request, OR of pending bits |
| halt_o | output | 1 | Sticky halt from checkstop |
| tb_run_o | output | 1 | Time base running |
| reset_req_o | output | 1 | One-cycle system reset request |

## Verification
Two functions can meet in one cycle: a falling-edge event on the machine-check pin that sets bit 2, and an acknowledge that clears it. The bench provokes this by driving pin 2 low with mchk_ack_i high on the same edge. It expects bit 2 to be set afterwards. It then expects a lone acknowledge in the next cycle to clear the bit and drop the summary request.

// File: rtl/pinc_pkg.sv
package pinc_pkg;
  localparam int unsigned PIN_EXT    = 0;
  localparam int unsigned PIN_SMI    = 1;
  localparam int unsigned PIN_MCHK   = 2;
  localparam int unsigned PIN_TBEN   = 3;
  localparam int unsigned PIN_CKSTOP = 4;
  localparam int unsigned PIN_HRST   = 5;
  localparam int unsigned PIN_SRST   = 6;
  localparam int unsigned NUM_FUNC   = 7;

  localparam int unsigned PEND_EXT  = 0;
  localparam int unsigned PEND_SMI  = 1;
  localparam int unsigned PEND_MCHK = 2;
  localparam int unsigned PEND_SRST = 3;
  localparam int unsigned PEND_W    = 4;
endpackage

// File: rtl/pinc_level_track.sv
module pinc_level_track #(
  parameter int unsigned NUM_PINS   = 8,
  parameter int unsigned NUM_FUNC   = 7,
  parameter logic [NUM_PINS-1:0] RST_LVL = '0,
  localparam int unsigned IDX_W     = $clog2(NUM_PINS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic                lvl_i,
  output logic [NUM_PINS-1:0] state_o,
  output logic [NUM_FUNC-1:0] chg_o
);
  logic [NUM_PINS-1:0] state_q;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic hit;
    assign hit = we_i && (idx_i == IDX_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  state_q[i] <= RST_LVL[i];
      else if (hit) state_q[i] <= lvl_i;
    end
    if (i < NUM_FUNC) begin : g_chg
      assign chg_o[i] = hit && (lvl_i != state_q[i]);
    end
  end

  assign state_o = state_q;

  assert_level_recorded_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> state_q[$past(idx_i)] == $past(lvl_i));
endmodule

// File: rtl/pinc_pending.sv
module pinc_pending
  import pinc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PEND_W-1:0] ev_i,
  input  logic              lvl_i,
  input  logic              ack_i,
  output logic [PEND_W-1:0] pend_o,
  output logic              req_o
);
  logic [PEND_W-1:0] pend_q, pend_d;
  logic              req_q;

  for (genvar b = 0; b < PEND_W; b++) begin : g_bit
    logic set, clr;
    if (b == PEND_MCHK) begin : g_edge
      assign set = ev_i[b] && !lvl_i;
      assign clr = ack_i;
    end else begin : g_lvl
      assign set = ev_i[b] && lvl_i;
      assign clr = ev_i[b] && !lvl_i;
    end
    // set has priority over clear
    assign pend_d[b] = set ? 1'b1 : (clr ? 1'b0 : pend_q[b]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      req_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      req_q  <= |pend_d;
    end
  end

  assign pend_o = pend_q;
  assign req_o  = req_q;

  assert_req_tracks_vector_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q == (pend_q != '0));
  assert_mchk_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q[PEND_MCHK] && !ack_i) |=> pend_q[PEND_MCHK]);
  assert_mchk_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i[PEND_MCHK] && !lvl_i && ack_i) |=> pend_q[PEND_MCHK]);
endmodule

// File: rtl/pinc_ctrl.sv
module pinc_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tb_ev_i,
  input  logic ckstop_ev_i,
  input  logic hrst_ev_i,
  input  logic lvl_i,
  output logic tb_run_o,
  output logic halt_o,
  output logic reset_req_o
);
  logic tb_q, halt_q, rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tb_q   <= 1'b0;
      halt_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      if (tb_ev_i) tb_q <= lvl_i;
      // checkstop halts until the next reset
      if (ckstop_ev_i && !lvl_i) halt_q <= 1'b1;
      rst_q <= hrst_ev_i && !lvl_i;
    end
  end

  assign tb_run_o    = tb_q;
  assign halt_o      = halt_q;
  assign reset_req_o = rst_q;

  assert_halt_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_q |=> halt_q);
  assert_reset_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |=> !rst_q);
  assert_tb_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tb_ev_i |=> tb_q == $past(lvl_i));
endmodule

// File: rtl/pin_conditioner.sv
module pin_conditioner
  import pinc_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter logic [NUM_PINS-1:0] RST_LVL = NUM_PINS'(8'h30),
  localparam int unsigned IDX_W = $clog2(NUM_PINS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pin_we_i,
  input  logic [IDX_W-1:0]    pin_idx_i,
  input  logic                pin_lvl_i,
  input  logic                mchk_ack_i,
  output logic [NUM_PINS-1:0] pin_state_o,
  output logic [PEND_W-1:0]   irq_pending_o,
  output logic                irq_req_o,
  output logic                halt_o,
  output logic                tb_run_o,
  output logic                reset_req_o
);
  logic [NUM_FUNC-1:0] chg;
  logic [PEND_W-1:0]   pend_ev;

  pinc_level_track #(
    .NUM_PINS (NUM_PINS),
    .NUM_FUNC (NUM_FUNC),
    .RST_LVL  (RST_LVL)
  ) u_track (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (pin_we_i),
    .idx_i   (pin_idx_i),
    .lvl_i   (pin_lvl_i),
    .state_o (pin_state_o),
    .chg_o   (chg)
  );

  always_comb begin
    pend_ev            = '0;
    pend_ev[PEND_EXT]  = chg[PIN_EXT];
    pend_ev[PEND_SMI]  = chg[PIN_SMI];
    pend_ev[PEND_MCHK] = chg[PIN_MCHK];
    pend_ev[PEND_SRST] = chg[PIN_SRST];
  end

  pinc_pending u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (pend_ev),
    .lvl_i  (pin_lvl_i),
    .ack_i  (mchk_ack_i),
    .pend_o (irq_pending_o),
    .req_o  (irq_req_o)
  );

  pinc_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tb_ev_i     (chg[PIN_TBEN]),
    .ckstop_ev_i (chg[PIN_CKSTOP]),
    .hrst_ev_i   (chg[PIN_HRST]),
    .lvl_i       (pin_lvl_i),
    .tb_run_o    (tb_run_o),
    .halt_o      (halt_o),
    .reset_req_o (reset_req_o)
  );

  assert_same_level_no_event_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_we_i && !mchk_ack_i && pin_lvl_i == pin_state_o[pin_idx_i])
    |=> ($stable(irq_pending_o) && $stable(halt_o) && $stable(tb_run_o) && !reset_req_o));
  assert_unused_pin_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_we_i && pin_idx_i == IDX_W'(NUM_FUNC) && !mchk_ack_i)
    |=> ($stable(irq_pending_o) && $stable(halt_o) && $stable(tb_run_o) && !reset_req_o));
endmodule

// File: tb/pin_conditioner_tb.sv
module pin_conditioner_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 22;

  // {req_id[3:0], we, idx[2:0], lvl, ack, pend[3:0], req, halt, tb, rst}
  localparam logic [17:0] VEC [NV] = '{
    18'b0001_0_000_0_0_0000_0_0_0_0, // R1 idle
    18'b0011_1_000_1_0_0001_1_0_0_0, // R3 ext high
    18'b0001_1_000_1_0_0001_1_0_0_0, // R1 ext repeat
    18'b0011_1_001_1_0_0011_1_0_0_0, // R3 smi high
    18'b1010_1_000_0_0_0010_1_0_0_0, // R10 ext low, req holds
    18'b0011_1_001_0_0_0000_0_0_0_0, // R3 smi low
    18'b0100_1_010_1_0_0000_0_0_0_0, // R4 mchk rise ignored
    18'b0100_1_010_0_0_0100_1_0_0_0, // R4 mchk fall sets
    18'b0100_1_010_1_0_0100_1_0_0_0, // R4 sticky after rise
    18'b0101_0_000_0_1_0000_0_0_0_0, // R5 ack clears
    18'b0110_1_011_1_0_0000_0_0_1_0, // R6 tb on
    18'b0110_1_011_1_0_0000_0_0_1_0, // R6 tb repeat
    18'b0110_1_011_0_0_0000_0_0_0_0, // R6 tb off
    18'b1001_1_110_1_0_1000_1_0_0_0, // R9 soft reset set
    18'b1001_1_110_0_0_0000_0_0_0_0, // R9 soft reset clear
    18'b1000_1_101_0_0_0000_0_0_0_1, // R8 hard reset low
    18'b1000_1_101_0_0_0000_0_0_0_0, // R8 repeat low, no pulse
    18'b1000_1_101_1_0_0000_0_0_0_0, // R8 release
    18'b0111_1_100_1_0_0000_0_0_0_0, // R7 ckstop already high
    18'b1011_1_111_1_0_0000_0_0_0_0, // R11 unused pin
    18'b0111_1_100_0_0_0000_0_1_0_0, // R7 ckstop low halts
    18'b0111_1_100_1_0_0000_0_1_0_0  // R7 halt sticky
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pin_we_i = 1'b0;
  logic [2:0] pin_idx_i = '0;
  logic       pin_lvl_i = 1'b0;
  logic       mchk_ack_i = 1'b0;
  logic [7:0] pin_state_o;
  logic [3:0] irq_pending_o;
  logic       irq_req_o, halt_o, tb_run_o, reset_req_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pin_conditioner u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_we_i(pin_we_i), .pin_idx_i(pin_idx_i),
    .pin_lvl_i(pin_lvl_i), .mchk_ack_i(mchk_ack_i), .pin_state_o(pin_state_o),
    .irq_pending_o(irq_pending_o), .irq_req_o(irq_req_o), .halt_o(halt_o),
    .tb_run_o(tb_run_o), .reset_req_o(reset_req_o)
  );

  task automatic check_out(input int req, input logic [7:0] exp);
    logic [7:0] act;
    act = {irq_pending_o, irq_req_o, halt_o, tb_run_o, reset_req_o};
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d outputs act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic check_state(input int req, input logic [7:0] exp);
    n_vec++;
    if (pin_state_o !== exp) begin
      n_bad++;
      $display("FAIL R%0d pin_state act=%h exp=%h", req, pin_state_o, exp);
    end
  endtask

  task automatic apply(input logic we, input logic [2:0] idx, input logic lvl, input logic ack);
    pin_we_i = we; pin_idx_i = idx; pin_lvl_i = lvl; mchk_ack_i = ack;
    @(posedge clk_i);
    @(negedge clk_i);
    pin_we_i = 1'b0; mchk_ack_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_out(10, 8'h00);  // R10 reset state
    check_state(2, 8'h30); // R2 reset levels

    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][13], VEC[v][12:10], VEC[v][9], VEC[v][8]);
      check_out(int'(VEC[v][17:14]), VEC[v][7:0]);
    end

    // R2 / R11: all writes recorded, including unused pin 7
    check_state(11, 8'hB4);

    // R5: falling edge and acknowledge in the same cycle, set wins
    apply(1'b1, 3'd2, 1'b0, 1'b1);
    check_out(5, 8'b0100_1_1_0_0);
    apply(1'b0, 3'd0, 1'b0, 1'b1);
    check_out(5, 8'b0000_0_1_0_0);

    // R11: pin 7 back to low, only its state bit moves
    apply(1'b1, 3'd7, 1'b0, 1'b0);
    check_out(11, 8'b0000_0_1_0_0);
    check_state(11, 8'h30);

    // R7: halt released only by reset
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_out(7, 8'h00);
    check_state(2, 8'h30);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule